// File: doc/BRIEF.md
# Shared-Bus External Memory Controller

This block bridges a 32-bit, single-beat processor slave port to an external 16-bit asynchronous memory bus. A pseudo-static RAM and a parallel NOR flash share that bus's address, data and control lines. One processor address bit chooses the device, and the controller drives only that device's active-low chip enable. All other external lines are common to both parts.

A request names a word-aligned byte address and a four-bit byte-enable mask. The controller works out which of the two 16-bit half-words in that word contain enabled bytes, and runs one external cycle for each of them, even half first. A full 32-bit access therefore costs two cycles, and an 8-bit or 16-bit access costs one. A build-time parameter sets where each memory byte sits on the processor data lanes: big-endian or little-endian. The shared data lines appear as separate input, output and output-enable signals, which the chip-level pad logic combines.

Each external cycle holds its strobes for a parameterised number of clocks. After it comes one recovery clock in which every enable is released. That gap keeps the controller's data drivers off the bus before any read begins.

Top module: `shared_mem_bridge`

## Requirements
- R1: After reset, `ram_ce_n`, `flash_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are high, and `mem_dq_oe` and `resp_ack` are low.
- R2: A request with `req_addr[ADDR_W-1]` = 0 asserts only `ram_ce_n` (low). A request with that bit = 1 asserts only `flash_ce_n`. The two chip enables are never low together.
- R3: A request whose enables cover both half-words runs two external cycles, on half-word addresses `{req_addr[ADDR_W-2:2],0}` and then that address plus one. `resp_ack` rises 2*WAIT_CYC+3 clocks after the clock that accepts the request.
- R4: A request whose enables fall in one half-word runs a single external cycle, and `resp_ack` rises WAIT_CYC+2 clocks after acceptance. In a write, only the strobes of enabled bytes go low: `mem_lb_n` for bits 7:0 and `mem_ub_n` for bits 15:8.
- R5: With BIG_ENDIAN=1, the byte at word offset o (o=0..3) travels on processor lane 3-o, where lane k means bits 8k+7:8k and the enable for lane k is `req_be[k]`. The memory byte at an even byte address is on external bits 7:0, and the byte at an odd address is on bits 15:8.
- R6: With BIG_ENDIAN=0, the byte at word offset o travels on processor lane o. The external half-word placement is the same as in R5.
- R7: In a read, `resp_rdata` carries the addressed bytes while `resp_ack` is high, and lanes whose enable is clear read as zero.
- R8: Every external cycle keeps its chip enable low for exactly WAIT_CYC clocks with `mem_addr` stable. At least one clock with both chip enables high separates consecutive cycles.
- R9: `mem_dq_oe` is high only while `mem_we_n` is low. It is never high while `mem_oe_n` is low, and it is low in the clock before `mem_oe_n` falls.
- R10: A request with `req_be` = 0 is acknowledged 1 clock after acceptance, with no chip enable asserted and no memory contents changed.
- R11: `resp_ack` is a one-clock pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `resp_ack` is seen |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 1:0 ignored, top bit selects the device |
| req_be | input | 4 | Byte enables, bit k for lane k |
| req_wdata | input | 32 | Write data |
| resp_ack | output | 1 | One-clock completion pulse |
| resp_rdata | output | 32 | Read data, valid with `resp_ack` |
| mem_addr | output | ADDR_W-2 | External half-word address |
| mem_din | input | 16 | Data from the shared bus |
| mem_dout | output | 16 | Data toward the shared bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dout` |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low-byte strobe, active low |
| mem_ub_n | output | 1 | High-byte strobe, active low |

## Verification
The controller accepts a request on the first clock at which it is idle. With the default of four active clocks, `resp_ack` is then due 1 clock later for an empty mask, 6 clocks later for a single half-word, and 11 clocks later for a full word. The bench drives each request just after a falling edge and counts rising edges until it sees `resp_ack` at a falling edge, then compares that count with these figures. It samples read data in the same half-cycle as the acknowledge, and checks one half-cycle later that the pulse has ended. It inspects the memory models' stored half-words only after the acknowledge, when every write strobe has already been captured. A falling-edge monitor records phase lengths, addresses and strobes for checking at the end of each access.

// File: rtl/emc_pkg.sv
package emc_pkg;

    localparam int BUS_W     = 32;
    localparam int BUS_BYTES = BUS_W / 8;
    localparam int MEM_W     = 16;
    localparam int MEM_BYTES = MEM_W / 8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ACT,
        SEQ_REC,
        SEQ_ACK
    } seq_state_e;

    typedef struct packed {
        logic                 we;
        logic                 to_flash;
        logic [BUS_BYTES-1:0] be;
        logic [BUS_W-1:0]     wdata;
    } bus_req_s;

    // Processor lane that carries the byte at word offset 'off'.
    function automatic logic [1:0] lane_of(input logic [1:0] off, input logic big);
        return big ? (2'd3 - off) : off;
    endfunction

    // Which half-words of a word hold at least one enabled byte.
    function automatic logic [1:0] halves_needed(input logic [BUS_BYTES-1:0] be, input logic big);
        logic [1:0] n;
        for (int h = 0; h < 2; h++) begin
            n[h] = be[lane_of(2'(2*h), big)] | be[lane_of(2'(2*h + 1), big)];
        end
        return n;
    endfunction

endpackage

// File: rtl/emc_lane_map.sv
module emc_lane_map
    import emc_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [BUS_BYTES-1:0] be,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 half,
    input  logic [BUS_W-1:0]     cap_bytes,   // byte at word offset o in [8o+7:8o]
    output logic [MEM_W-1:0]     wr_half,
    output logic [MEM_BYTES-1:0] strb,
    output logic [BUS_W-1:0]     rdata
);

    // Read assembly: each word offset lands on its lane, masked by its enable.
    for (genvar o = 0; o < BUS_BYTES; o++) begin : g_rd
        localparam int LN = BIG_ENDIAN ? (BUS_BYTES - 1 - o) : o;
        assign rdata[8*LN +: 8] = be[LN] ? cap_bytes[8*o +: 8] : 8'h00;
    end

    // Write path: memory lane m of the current half-word holds offset {half, m}.
    for (genvar m = 0; m < MEM_BYTES; m++) begin : g_wr
        logic [1:0] ln;
        always_comb begin
            ln                = lane_of({half, 1'(m)}, BIG_ENDIAN);
            wr_half[8*m +: 8] = wdata[8*ln +: 8];
            strb[m]           = be[ln];
        end
    end

endmodule

// File: rtl/emc_seq.sv
module emc_seq
    import emc_pkg::*;
#(
    parameter int WAIT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] need_in,
    output logic       accept,
    output logic       active,
    output logic       half,
    output logic       capture,
    output logic       ack
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             half_q;
    logic [1:0]       need_q;

    assign accept  = (state_q == SEQ_IDLE) && start;
    assign active  = (state_q == SEQ_ACT);
    assign capture = active && (cnt_q == LAST);
    assign ack     = (state_q == SEQ_ACK);
    assign half    = half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            half_q  <= 1'b0;
            need_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    need_q <= need_in;
                    cnt_q  <= '0;
                    half_q <= ~need_in[0];
                    state_q <= (need_in == 2'b00) ? SEQ_ACK : SEQ_ACT;
                end
                SEQ_ACT: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        state_q <= SEQ_REC;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_REC: begin
                    if (!half_q && need_q[1]) begin
                        half_q  <= 1'b1;
                        state_q <= SEQ_ACT;
                    end else begin
                        state_q <= SEQ_ACK;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shared_mem_bridge.sv
module shared_mem_bridge
    import emc_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int WAIT_CYC   = 4,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int MEM_AW    = ADDR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BUS_BYTES-1:0] req_be,
    input  logic [BUS_W-1:0]     req_wdata,
    output logic                 resp_ack,
    output logic [BUS_W-1:0]     resp_rdata,
    output logic [MEM_AW-1:0]    mem_addr,
    input  logic [MEM_W-1:0]     mem_din,
    output logic [MEM_W-1:0]     mem_dout,
    output logic                 mem_dq_oe,
    output logic                 ram_ce_n,
    output logic                 flash_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 mem_lb_n,
    output logic                 mem_ub_n
);

    localparam int SEL_BIT = ADDR_W - 1;
    localparam int BASE_W  = MEM_AW - 1;

    bus_req_s               req_q;
    logic [BASE_W-1:0]      base_q;
    logic [BUS_W-1:0]       cap_q;
    logic                   accept, active, half, capture;
    logic [MEM_BYTES-1:0]   strb;

    emc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (req_valid),
        .need_in (halves_needed(req_be, BIG_ENDIAN)),
        .accept  (accept),
        .active  (active),
        .half    (half),
        .capture (capture),
        .ack     (resp_ack)
    );

    emc_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) u_lanes (
        .be        (req_q.be),
        .wdata     (req_q.wdata),
        .half      (half),
        .cap_bytes (cap_q),
        .wr_half   (mem_dout),
        .strb      (strb),
        .rdata     (resp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            base_q <= '0;
            cap_q  <= '0;
        end else begin
            if (accept) begin
                req_q.we       <= req_we;
                req_q.to_flash <= req_addr[SEL_BIT];
                req_q.be       <= req_be;
                req_q.wdata    <= req_wdata;
                base_q         <= req_addr[SEL_BIT-1:2];
            end
            if (capture) begin
                if (half) cap_q[31:16] <= mem_din;
                else      cap_q[15:0]  <= mem_din;
            end
        end
    end

    assign mem_addr   = {base_q, half};
    assign ram_ce_n   = ~(active & ~req_q.to_flash);
    assign flash_ce_n = ~(active &  req_q.to_flash);
    assign mem_oe_n   = ~(active & ~req_q.we);
    assign mem_we_n   = ~(active &  req_q.we);
    assign mem_dq_oe  = active & req_q.we;
    assign mem_lb_n   = ~(active & strb[0]);
    assign mem_ub_n   = ~(active & strb[1]);

endmodule

// File: rtl/emc_bridge_checker.sv
module emc_bridge_checker #(
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst,
    input logic          ram_ce_n,
    input logic          flash_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe,
    input logic [AW-1:0] mem_addr,
    input logic          resp_ack
);

    logic any_ce;
    assign any_ce = ~ram_ce_n | ~flash_ce_n;

    p_one_ce_r2: assert property (@(posedge clk) disable iff (rst)
        !(!ram_ce_n && !flash_ce_n));

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (any_ce && $past(any_ce)) |-> $stable(mem_addr));

    p_dq_write_only_r9: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);

    p_no_clash_r9: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    p_turnaround_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        resp_ack |=> !resp_ack);

    p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
        resp_ack |-> !any_ce);

endmodule

bind shared_mem_bridge emc_bridge_checker #(.AW(MEM_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ram_ce_n   (ram_ce_n),
    .flash_ce_n (flash_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr),
    .resp_ack   (resp_ack)
);

// File: tb/shared_mem_bridge_bench.sv
`timescale 1ns/1ps

module emc_mem_model (
    input  logic        clk,
    input  logic [5:0]  addr,
    input  logic        ram_ce_n,
    input  logic        flash_ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        lb_n,
    input  logic        ub_n,
    input  logic [15:0] wr,
    output logic [15:0] rd
);
    logic [15:0] ram   [64];
    logic [15:0] flash [64];

    initial begin
        for (int i = 0; i < 64; i++) begin
            ram[i]   = 16'h0000;
            flash[i] = 16'h0000;
        end
    end

    always @(posedge clk) begin
        if (!we_n && !ram_ce_n) begin
            if (!lb_n) ram[addr][7:0]  <= wr[7:0];
            if (!ub_n) ram[addr][15:8] <= wr[15:8];
        end
        if (!we_n && !flash_ce_n) begin
            if (!lb_n) flash[addr][7:0]  <= wr[7:0];
            if (!ub_n) flash[addr][15:8] <= wr[15:8];
        end
    end

    assign rd = (!oe_n && !ram_ce_n)   ? ram[addr]   :
                (!oe_n && !flash_ce_n) ? flash[addr] : 16'h0000;
endmodule

module shared_mem_bridge_bench;
    localparam int W      = 4;
    localparam int ADDR_W = 24;
    localparam int MAW    = ADDR_W - 2;
    localparam int LAT1   = W + 2;
    localparam int LAT2   = 2 * W + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_we    = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [3:0]        req_be    = '0;
    logic [31:0]       req_wdata = '0;

    logic        m_ack, l_ack;
    logic [31:0] m_rdata, l_rdata;
    logic [MAW-1:0] m_addr, l_addr;
    logic [15:0] m_din, m_dout, l_din, l_dout;
    logic m_oe, m_rce, m_fce, m_oen, m_wen, m_lbn, m_ubn;
    logic l_oe, l_rce, l_fce, l_oen, l_wen, l_lbn, l_ubn;

    shared_mem_bridge #(.ADDR_W(ADDR_W), .WAIT_CYC(W), .BIG_ENDIAN(1'b1)) u_shared_mem_bridge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .resp_ack(m_ack), .resp_rdata(m_rdata),
        .mem_addr(m_addr), .mem_din(m_din), .mem_dout(m_dout), .mem_dq_oe(m_oe),
        .ram_ce_n(m_rce), .flash_ce_n(m_fce), .mem_oe_n(m_oen), .mem_we_n(m_wen),
        .mem_lb_n(m_lbn), .mem_ub_n(m_ubn));

    shared_mem_bridge #(.ADDR_W(ADDR_W), .WAIT_CYC(W), .BIG_ENDIAN(1'b0)) u_shared_mem_bridge_le (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .resp_ack(l_ack), .resp_rdata(l_rdata),
        .mem_addr(l_addr), .mem_din(l_din), .mem_dout(l_dout), .mem_dq_oe(l_oe),
        .ram_ce_n(l_rce), .flash_ce_n(l_fce), .mem_oe_n(l_oen), .mem_we_n(l_wen),
        .mem_lb_n(l_lbn), .mem_ub_n(l_ubn));

    emc_mem_model u_mem_be (.clk(clk), .addr(m_addr[5:0]), .ram_ce_n(m_rce), .flash_ce_n(m_fce),
        .oe_n(m_oen), .we_n(m_wen), .lb_n(m_lbn), .ub_n(m_ubn), .wr(m_dout), .rd(m_din));
    emc_mem_model u_mem_le (.clk(clk), .addr(l_addr[5:0]), .ram_ce_n(l_rce), .flash_ce_n(l_fce),
        .oe_n(l_oen), .we_n(l_wen), .lb_n(l_lbn), .ub_n(l_ubn), .wr(l_dout), .rd(l_din));

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // falling-edge bus monitor on the big-endian instance
    int       mon_phases, mon_run;
    logic [MAW-1:0] mon_a0, mon_a1, prev_addr;
    bit mon_ram, mon_flash, mon_lb_w, mon_ub_w, mon_bad_len, mon_unstable;
    bit prev_act = 1'b0, prev_dq = 1'b0;
    int clash_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit act = !m_rce || !m_fce;
            if (!m_rce && !m_fce) clash_cnt++;
            if (m_oe && (!m_oen || m_wen)) clash_cnt++;
            if (!m_oen && prev_dq) clash_cnt++;
            if (act && !prev_act) begin
                if (mon_phases == 0) mon_a0 = m_addr;
                if (mon_phases == 1) mon_a1 = m_addr;
                mon_phases++;
                mon_run = 1;
            end else if (act) begin
                mon_run++;
                if (m_addr != prev_addr) mon_unstable = 1'b1;
            end
            if (!act && prev_act && mon_run != W) mon_bad_len = 1'b1;
            if (!m_rce) mon_ram = 1'b1;
            if (!m_fce) mon_flash = 1'b1;
            if (act && !m_wen) begin
                if (!m_lbn) mon_lb_w = 1'b1;
                if (!m_ubn) mon_ub_w = 1'b1;
            end
            prev_act  = act;
            prev_dq   = m_oe;
            prev_addr = m_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output int lat,
                          output logic [31:0] rb, output logic [31:0] rl);
        @(negedge clk);
        mon_phases = 0; mon_run = 0; mon_ram = 0; mon_flash = 0;
        mon_lb_w = 0; mon_ub_w = 0; mon_bad_len = 0; mon_unstable = 0;
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!m_ack && lat < 100);
        chk(lat < 100, "R3 access hung", 32'(lat), 32'd100);
        chk(l_ack == 1'b1, "R6 little-endian instance ack in step", {31'd0, l_ack}, 32'd1);
        rb = m_rdata;
        rl = l_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!m_ack, "R11 ack lasts one clock", {31'd0, m_ack}, 32'd0);
    endtask

    task automatic t_reset();
        chk({m_rce, m_fce, m_oen, m_wen, m_lbn, m_ubn, m_oe, m_ack} == 8'b1111_1100,
            "R1 reset state", {24'd0, m_rce, m_fce, m_oen, m_wen, m_lbn, m_ubn, m_oe, m_ack},
            32'h0000_00FC);
    endtask

    task automatic t_word_write();
        int lat; logic [31:0] rb, rl;
        access(1'b1, 24'h000010, 4'b1111, 32'hA1B2C3D4, lat, rb, rl);
        chk(lat == LAT2, "R3 word write latency", 32'(lat), 32'(LAT2));
        chk(mon_phases == 2, "R3 two external cycles", 32'(mon_phases), 32'd2);
        chk(mon_a0 == 22'd8 && mon_a1 == 22'd9, "R3 half-word order", {mon_a0[7:0], mon_a1[7:0]}, 32'h0809);
        chk(mon_ram && !mon_flash, "R2 RAM selected", {mon_ram, mon_flash}, 32'd2);
        chk(!mon_bad_len && !mon_unstable, "R8 phase length and address", {mon_bad_len, mon_unstable}, 32'd0);
        chk(u_mem_be.ram[8] == 16'hB2A1 && u_mem_be.ram[9] == 16'hD4C3, "R5 big-endian placement",
            {u_mem_be.ram[9], u_mem_be.ram[8]}, 32'hD4C3_B2A1);
        chk(u_mem_le.ram[8] == 16'hC3D4 && u_mem_le.ram[9] == 16'hA1B2, "R6 little-endian placement",
            {u_mem_le.ram[9], u_mem_le.ram[8]}, 32'hA1B2_C3D4);
    endtask

    task automatic t_word_read();
        int lat; logic [31:0] rb, rl;
        access(1'b0, 24'h000010, 4'b1111, 32'h0, lat, rb, rl);
        chk(lat == LAT2, "R3 word read latency", 32'(lat), 32'(LAT2));
        chk(rb == 32'hA1B2C3D4, "R5 big-endian read", rb, 32'hA1B2C3D4);
        chk(rl == 32'hA1B2C3D4, "R6 little-endian read", rl, 32'hA1B2C3D4);
        chk(!mon_bad_len, "R8 read phase length", {31'd0, mon_bad_len}, 32'd0);
    endtask

    task automatic t_byte_write_flash();
        int lat; logic [31:0] rb, rl;
        access(1'b1, 24'h800020, 4'b0100, 32'h005A0000, lat, rb, rl);
        chk(lat == LAT1, "R4 byte write latency", 32'(lat), 32'(LAT1));
        chk(mon_phases == 1 && mon_a0 == 22'h10, "R4 single cycle address", {mon_phases[7:0], mon_a0[7:0]}, 32'h0110);
        chk(mon_flash && !mon_ram, "R2 flash selected", {mon_ram, mon_flash}, 32'd1);
        chk(mon_ub_w && !mon_lb_w, "R4 only high strobe", {mon_lb_w, mon_ub_w}, 32'd1);
        chk(u_mem_be.flash[16] == 16'h5A00, "R5 byte at odd address", {16'd0, u_mem_be.flash[16]}, 32'h5A00);
        chk(u_mem_le.flash[17] == 16'h005A && u_mem_le.flash[16] == 16'h0000, "R6 byte at offset 2",
            {u_mem_le.flash[17], u_mem_le.flash[16]}, 32'h005A_0000);
    endtask

    task automatic t_half_read();
        int lat; logic [31:0] rb, rl;
        access(1'b0, 24'h000010, 4'b0011, 32'h0, lat, rb, rl);
        chk(lat == LAT1, "R4 half read latency", 32'(lat), 32'(LAT1));
        chk(mon_phases == 1 && mon_a0 == 22'd9, "R5 upper half address", {mon_phases[7:0], mon_a0[7:0]}, 32'h0109);
        chk(rb == 32'h0000C3D4, "R7 big-endian masked read", rb, 32'h0000C3D4);
        chk(rl == 32'h0000C3D4, "R7 little-endian masked read", rl, 32'h0000C3D4);
    endtask

    task automatic t_byte_merge();
        int lat; logic [31:0] rb, rl;
        access(1'b1, 24'h000010, 4'b1000, 32'hEE000000, lat, rb, rl);
        chk(mon_lb_w && !mon_ub_w, "R4 only low strobe", {mon_lb_w, mon_ub_w}, 32'd2);
        chk(u_mem_be.ram[8] == 16'hB2EE, "R4 neighbour byte kept", {16'd0, u_mem_be.ram[8]}, 32'hB2EE);
        chk(u_mem_le.ram[9] == 16'hEEB2, "R6 offset 3 high lane", {16'd0, u_mem_le.ram[9]}, 32'hEEB2);
        access(1'b0, 24'h000010, 4'b1111, 32'h0, lat, rb, rl);
        chk(rb == 32'hEEB2C3D4 && rl == 32'hEEB2C3D4, "R7 merged word read", rb, 32'hEEB2C3D4);
    endtask

    task automatic t_zero_be();
        int lat; logic [31:0] rb, rl;
        access(1'b1, 24'h000010, 4'b0000, 32'hFFFFFFFF, lat, rb, rl);
        chk(lat == 1, "R10 empty mask latency", 32'(lat), 32'd1);
        chk(mon_phases == 0, "R10 no chip enable", 32'(mon_phases), 32'd0);
        chk(u_mem_be.ram[8] == 16'hB2EE && u_mem_be.ram[9] == 16'hD4C3, "R10 memory unchanged",
            {u_mem_be.ram[9], u_mem_be.ram[8]}, 32'hD4C3_B2EE);
    endtask

    task automatic t_bus_safety();
        chk(clash_cnt == 0, "R9 and R2 bus ownership", 32'(clash_cnt), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_write();
        t_word_read();
        t_byte_write_flash();
        t_half_read();
        t_byte_merge();
        t_zero_be();
        t_bus_safety();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R3 actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule